// File: doc/BRIEF.md
# Manual Reset Input Qualifier

This block takes a raw, active-low manual reset line (from a push switch shorted to ground or from a logic gate) and turns it into one clean, level-type manual-reset request for the chip's reset sequencer. The line is brought into the clock domain through a flop synchronizer. It is then filtered on a slow timing tick, nominally one pulse per millisecond, supplied by the surrounding logic.

A press is accepted only after the synchronized line has been low for an unbroken run of ticks. The request then holds for as long as the line stays low. It is withdrawn only after an equally unbroken run of high ticks. Contact bounce in either direction restarts the run that is being counted. This means one press produces exactly one request, and the request is never dropped early.

Timing of the reset stretch after release is left to the sequencer. Both run lengths are parameters, defaulting to 20 ticks.

Top module: `mrf_manual_reset_filter`

## Requirements
- R1: Directly after reset the request output `mr_req` is 0, and the synchronizer treats the line as high (not pressed).
- R2: Reset is synchronous and active low. Taking `rst_n` low while the request is asserted clears `mr_req` at the next clock edge.
- R3: While the line is low for fewer than PRESS_TICKS consecutive ticks, `mr_req` stays 0.
- R4: Any clock cycle in which the synchronized line is high, while no request is active, restarts the low-tick count from zero.
- R5: On the tick that completes PRESS_TICKS consecutive low ticks, `mr_req` becomes 1 at that clock edge, and it stays 1 for as long as the line stays low.
- R6: After release, `mr_req` stays 1 until RELEASE_TICKS consecutive high ticks have been seen. Any low cycle while the request is active restarts the high-tick count.
- R7: On the tick that completes RELEASE_TICKS consecutive high ticks, `mr_req` returns to 0 at that clock edge.
- R8: Time advances only on `tick` pulses, so a low line with no ticks never raises `mr_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timing pulse, nominally every 1 ms |
| btn_n | input | 1 | Raw asynchronous manual reset line, low means pressed |
| mr_req | output | 1 | Qualified manual-reset request, high while active |

## Verification
The bench holds the line low for one tick short of the press length. A design with an off-by-one count would raise the request there, or one tick late at the boundary. A single-cycle high glitch is placed in the middle of a press, and a single-cycle low glitch in the middle of a release. A filter that only pauses its count, instead of restarting it, would assert or release early. The line is also held low with no ticks at all, to catch a design that counts clock cycles rather than ticks. Finally, reset is applied while the request is active, to catch a request that survives reset.

// File: rtl/mrf_pkg.sv
// Package: shared types for the manual reset filter.
// Assumes: nothing beyond the two-state qualification scheme.
package mrf_pkg;
    typedef enum logic {
        MRF_IDLE = 1'b0,   // no request, counting low ticks
        MRF_HELD = 1'b1    // request active, counting high ticks
    } mrf_state_e;
endpackage

// File: rtl/mrf_sync.sv
// Module: mrf_sync
// Brings an asynchronous single-bit input into the clk domain with a flop chain.
// Assumes: STAGES >= 2; on reset every stage takes RST_VAL.
module mrf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mrf_run_counter.sv
// Module: mrf_run_counter
// Counts consecutive advance pulses; flags hit on the pulse that reaches last.
// Assumes: clr has priority over adv; the count wraps to zero on a hit.
module mrf_run_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] last,
    output logic             hit,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    // Detect the pulse that completes the run.
    always_comb begin
        hit = adv && !clr && (cnt_q == last);
    end

    // Advance, clear or wrap the run count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (hit)      cnt_q <= '0;
        else if (adv)      cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
endmodule

// File: rtl/mrf_manual_reset_filter.sv
// Module: mrf_manual_reset_filter (top)
// Qualifies an active-low manual reset line into a level request: press needs
// PRESS_TICKS unbroken low ticks, release needs RELEASE_TICKS unbroken high ticks.
// Assumes: tick is a one-cycle pulse; btn_n idles high (not pressed).
module mrf_manual_reset_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int PRESS_TICKS   = 20,
    parameter int RELEASE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic mr_req
);
    import mrf_pkg::*;

    localparam int MAX_TICKS = (PRESS_TICKS > RELEASE_TICKS) ? PRESS_TICKS : RELEASE_TICKS;
    localparam int CNT_W     = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS);
    localparam logic [CNT_W-1:0] PRESS_LAST   = CNT_W'(PRESS_TICKS - 1);
    localparam logic [CNT_W-1:0] RELEASE_LAST = CNT_W'(RELEASE_TICKS - 1);

    mrf_state_e       state_q;
    logic             sync_n;
    logic             level_ok;
    logic             run_hit;
    logic [CNT_W-1:0] run_last;
    logic [CNT_W-1:0] run_cnt;

    mrf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (btn_n),
        .q     (sync_n)
    );

    // Pick which level continues the run and how long the run must be.
    always_comb begin
        if (state_q == MRF_IDLE) begin
            level_ok = !sync_n;
            run_last = PRESS_LAST;
        end else begin
            level_ok = sync_n;
            run_last = RELEASE_LAST;
        end
    end

    mrf_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!level_ok),
        .adv   (tick && level_ok),
        .last  (run_last),
        .hit   (run_hit),
        .count (run_cnt)
    );

    // Toggle between idle and held when a run completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= MRF_IDLE;
        else if (run_hit) state_q <= (state_q == MRF_IDLE) ? MRF_HELD : MRF_IDLE;
    end

    assign mr_req = (state_q == MRF_HELD);
endmodule

// File: rtl/mrf_checker.sv
// Module: mrf_checker
// Temporal checks on the manual reset filter, attached by bind below.
// Assumes: sync_n and cnt are the top's synchronizer output and run count.
module mrf_checker #(
    parameter int CNT_W    = 5,
    parameter int MAX_LAST = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             sync_n,
    input logic             mr_req,
    input logic [CNT_W-1:0] cnt
);
    AST_RESET_CLEARS_REQ: assert property (@(posedge clk) !rst_n |=> !mr_req); // R2
    AST_IDLE_HIGH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && !mr_req) |=> !mr_req); // R4
    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_req) |-> $past(!sync_n)); // R5
    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && mr_req) |=> mr_req); // R6
    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mr_req) |-> ($past(sync_n) || $past(!rst_n))); // R7
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_req) |-> $past(tick)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_LAST)); // R3
endmodule

bind mrf_manual_reset_filter mrf_checker #(
    .CNT_W    (CNT_W),
    .MAX_LAST (MAX_TICKS - 1)
) u_mrf_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .sync_n (sync_n),
    .mr_req (mr_req),
    .cnt    (run_cnt)
);

// File: tb/tb_mrf_manual_reset_filter.sv
module tb_mrf_manual_reset_filter;
    localparam int PRESS   = 20;
    localparam int RELEASE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic mr_req;
    int   checks = 0;
    int   errors = 0;

    always #4 clk = ~clk;

    mrf_manual_reset_filter #(.PRESS_TICKS(PRESS), .RELEASE_TICKS(RELEASE)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n), .mr_req(mr_req)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (mr_req !== exp) begin
            errors++;
            $display("FAIL %s: mr_req=%b expected %b at %0t", req, mr_req, exp, $time);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic set_line(input logic v);
        @(negedge clk) btn_n = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic glitch(input logic v);
        @(negedge clk) btn_n = v;
        @(negedge clk) btn_n = ~v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        tick_n(3);
        check("R1", 1'b0);
    endtask

    task automatic t_short_press;
        set_line(1'b0);
        tick_n(PRESS - 1);
        check("R3", 1'b0);
        set_line(1'b1);
        tick_n(2);
        check("R3", 1'b0);
    endtask

    task automatic t_bounce_press;
        set_line(1'b0);
        tick_n(10);
        glitch(1'b1);
        tick_n(PRESS - 1);
        check("R4", 1'b0);
        tick_n(1);
        check("R5", 1'b1);
        tick_n(50);
        check("R5", 1'b1);
    endtask

    task automatic t_release;
        set_line(1'b1);
        tick_n(RELEASE - 1);
        check("R6", 1'b1);
        glitch(1'b0);
        tick_n(RELEASE - 1);
        check("R6", 1'b1);
        tick_n(1);
        check("R7", 1'b0);
        tick_n(5);
        check("R7", 1'b0);
    endtask

    task automatic t_no_tick;
        set_line(1'b0);
        repeat (300) @(negedge clk);
        check("R8", 1'b0);
        set_line(1'b1);
    endtask

    task automatic t_reset_while_held;
        set_line(1'b0);
        tick_n(PRESS);
        check("R5", 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R2", 1'b0);
        rst_n = 1'b1;
        set_line(1'b1);
        tick_n(2);
        check("R2", 1'b0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_short_press();
        t_bounce_press();
        t_release();
        t_no_tick();
        t_reset_while_held();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule